// File: doc/BRIEF.md
# Transmit Inter-Frame Gap Inserter for a 64-bit XGMII-Style Bus

This block sits between a transmit frame source and a 64-bit, single-data-rate, eight-lane transmit bus of the XGMII kind, clocked at 156.25 MHz with one word per rising edge. It turns source words into bus words. The first lane of a frame becomes a start character. The lane after the last valid byte becomes a terminate character. All unused lanes carry idle. After every frame it sends idle words until the required inter-frame gap is covered. While the gap is being sent it holds the source off through a ready signal.

The gap comes from a five-bit setting counted in four-byte steps on top of an eight-byte floor. A new frame always begins on lane 0, so the gap actually sent is the setting rounded up to the next word boundary. An optional stretch mode slows the effective payload rate to suit a SONET-class line. It adds one idle byte for every thirteen data bytes sent, hands out the accumulated extra in whole four-byte units at each frame end, and carries any remainder forward. A transmit-enable input stops all acceptance and forces idle output.

The source keeps `src_valid` high for every word of a frame once it has started. An accepted word appears on the bus one clock later.

Top module: `xgmii_tx_gap`

## Requirements
- R1: Data bytes leave on their own lanes, in order, with the lane control flag 0. On the first word of a frame (`src_sop`), lane 0 is replaced by the control character 0xFB. A start character never appears on any lane other than lane 0.
- R2: `src_tail` gives how many lanes of the last word (`src_eop`) are valid: 1 to 7, with 0 meaning all 8. The lane just after the last valid byte carries 0xFD with its flag set, and the lanes above it carry 0x07 with their flag set. When the last word is full, the next bus word has 0xFD on lane 0 and 0x07 on lanes 1 to 7. At most one terminate character appears per word.
- R3: With stretch off and the next frame waiting, the gap is counted in control bytes from the terminate character (included) up to the next start character (excluded). It equals the smallest value g that is at least 8 + 4·`gap_cfg` and for which g + (valid lanes of the last word) is a multiple of 8.
- R4: A `gap_cfg` of 0 gives the 8-byte floor, and a `gap_cfg` of 31 gives a floor of 132 bytes. Both are rounded as in R3.
- R5: An accepted word appears on the bus one clock after the edge that accepts it. `src_ready` goes low in the cycle after a last word is accepted and stays low until the gap has been sent.
- R6: A control-flagged lane only ever carries 0x07, 0xFB or 0xFD. When no frame word or terminate is pending, all eight lanes carry 0x07 with their flags set.
- R7: While `tx_enable` is low, `src_ready` is low and nothing is accepted. From the next clock the bus carries only idle words, and the remaining gap count is frozen.
- R8: With `stretch_en` set, one extra idle byte accrues for every 13 data bytes, where data bytes are the lanes with flag 0, so a start word contributes 7. At each frame end the accrued extra, rounded down to a multiple of 4, is added to the R3 floor. The leftover count below 13 and the leftover extra below 4 are carried into the next frame.
- R9: During and right after a synchronous active-low reset, the bus carries idle on all lanes and `src_ready` is high when `tx_enable` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, 156.25 MHz |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_enable | input | 1 | Transmit enable; low forces idle and blocks the source |
| gap_cfg | input | 5 | Gap setting in 4-byte steps above the 8-byte floor |
| stretch_en | input | 1 | Enables rate-stretch idle insertion |
| src_valid | input | 1 | Source word valid |
| src_sop | input | 1 | Source word is the first of a frame |
| src_eop | input | 1 | Source word is the last of a frame |
| src_tail | input | 3 | Valid lanes in the last word, 0 meaning all 8 |
| src_data | input | 64 | Source word, lane 0 in bits 7:0 |
| src_ready | output | 1 | Block accepts a word at the next edge |
| xgmii_txd | output | 64 | Bus data, lane 0 in bits 7:0 |
| xgmii_txc | output | 8 | Per-lane control flag, 1 for a control character |

## Verification
The gap is measured on the bus across pairs of frames. The test pairs vary the tail lane count (1, 3, 4, 5 and a full word) and the gap setting (0, 2, 5 and 31). This separates the byte-accurate floor from the rounding to a lane-0 start, and shows whether the partial last word is counted as part of the gap. The full-tail case is the only one that shows whether the terminate character moves into the following word. A single-word frame shows start and terminate sharing one word. A run of stretched frames of differing lengths shows whether the extra idle is rounded to four-byte units and whether both remainders carry over from one frame to the next. Holding a valid frame against a low enable shows that acceptance is blocked and only idles are sent.

// File: rtl/xgmii_gap_pkg.sv
// Shared character codes and state encoding for the transmit gap inserter.
// Assumes an eight-bit character per lane.
package xgmii_gap_pkg;
    localparam logic [7:0] CH_IDLE  = 8'h07;
    localparam logic [7:0] CH_START = 8'hFB;
    localparam logic [7:0] CH_TERM  = 8'hFD;

    typedef enum logic {
        ST_OPEN = 1'b0,   // frame words may be accepted
        ST_GAP  = 1'b1    // idle gap in progress, source held off
    } gap_state_e;
endpackage

// File: rtl/xgmii_lane_mapper.sv
// Builds one bus word from the current source word or from a gap request.
// Purely combinational. Assumes tail_cnt lies in 1..LANES whenever eop is set.
module xgmii_lane_mapper
    import xgmii_gap_pkg::*;
#(
    parameter int LANES = 8,
    parameter int CNT_W = 4
) (
    input  logic                 frame_word,
    input  logic                 term_word,
    input  logic                 sop,
    input  logic                 eop,
    input  logic [CNT_W-1:0]     tail_cnt,
    input  logic [8*LANES-1:0]   data,
    output logic [8*LANES-1:0]   txd,
    output logic [LANES-1:0]     txc,
    output logic [CNT_W-1:0]     data_cnt
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] lane_b;
        logic       lane_c;

        // Choose start, data, terminate or idle for this lane.
        always_comb begin
            if (frame_word && sop && (i == 0)) begin
                lane_c = 1'b1;
                lane_b = CH_START;
            end else if (frame_word && eop && (CNT_W'(i) >= tail_cnt)) begin
                lane_c = 1'b1;
                lane_b = (CNT_W'(i) == tail_cnt) ? CH_TERM : CH_IDLE;
            end else if (frame_word) begin
                lane_c = 1'b0;
                lane_b = data[8*i +: 8];
            end else if (term_word && (i == 0)) begin
                lane_c = 1'b1;
                lane_b = CH_TERM;
            end else begin
                lane_c = 1'b1;
                lane_b = CH_IDLE;
            end
        end

        assign txd[8*i +: 8] = lane_b;
        assign txc[i]        = lane_c;
    end

    // Count the lanes that leave as data, for the stretch accumulator.
    always_comb begin
        if (frame_word)
            data_cnt = (eop ? tail_cnt : CNT_W'(LANES)) - (sop ? CNT_W'(1) : CNT_W'(0));
        else
            data_cnt = '0;
    end

endmodule

// File: rtl/xgmii_stretch_acc.sv
// Rate-stretch accumulator: one extra idle byte per DIV data bytes, handed
// out at frame end in whole UNIT-byte steps, remainders carried onward.
// Assumes add_bytes never exceeds DIV, so at most one wrap per cycle.
module xgmii_stretch_acc #(
    parameter int CNT_W = 4,
    parameter int DIV   = 13,
    parameter int UNIT  = 4,
    parameter int EXT_W = 12,
    parameter int OUT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stretch_en,
    input  logic             count_en,
    input  logic [CNT_W-1:0] add_bytes,
    input  logic             close,
    output logic [OUT_W-1:0] extra_bytes
);

    localparam int REM_W = $clog2(DIV);
    localparam int SUM_W = ((REM_W > CNT_W) ? REM_W : CNT_W) + 1;

    logic [REM_W-1:0] rem_q;
    logic [EXT_W-1:0] ext_q;
    logic [SUM_W-1:0] rem_sum;
    logic             wrap;
    logic [REM_W-1:0] rem_nx;
    logic [EXT_W-1:0] ext_sum;
    logic [EXT_W-1:0] ext_round;

    // Add this word's data bytes and fold whole DIV-byte groups into extras.
    always_comb begin
        rem_sum   = SUM_W'(rem_q) + (count_en ? SUM_W'(add_bytes) : SUM_W'(0));
        wrap      = (rem_sum >= SUM_W'(DIV));
        rem_nx    = wrap ? REM_W'(rem_sum - SUM_W'(DIV)) : REM_W'(rem_sum);
        ext_sum   = ext_q + EXT_W'(wrap);
        ext_round = (ext_sum / EXT_W'(UNIT)) * EXT_W'(UNIT);
        extra_bytes = (stretch_en && close) ? OUT_W'(ext_round) : '0;
    end

    // Hold remainders while stretching; clear them when stretch is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !stretch_en) begin
            rem_q <= '0;
            ext_q <= '0;
        end else begin
            rem_q <= rem_nx;
            ext_q <= close ? (ext_sum - ext_round) : ext_sum;
        end
    end

    // R8
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q < REM_W'(DIV));

    // R8
    carry_below_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (close && stretch_en) |=> (ext_q < EXT_W'(UNIT)));

endmodule

// File: rtl/xgmii_gap_ctrl.sv
// Frame/gap sequencer: accepts source words, then after each frame end
// counts the remaining gap down in bytes, one word per enabled cycle.
// Assumes a frame's words arrive back to back once started.
module xgmii_gap_ctrl
    import xgmii_gap_pkg::*;
#(
    parameter int LANES     = 8,
    parameter int GAP_W     = 5,
    parameter int MIN_GAP   = 8,
    parameter int GAP_UNIT  = 4,
    parameter int CNT_W     = 4,
    parameter int GAP_CNT_W = 19
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_enable,
    input  logic [GAP_W-1:0]     gap_cfg,
    input  logic                 src_valid,
    input  logic                 src_sop,
    input  logic                 src_eop,
    input  logic [CNT_W-1:0]     tail_cnt,
    input  logic [GAP_CNT_W-1:0] stretch_bytes,
    output logic                 src_ready,
    output logic                 accept,
    output logic                 close,
    output logic                 term_word
);

    gap_state_e           state_q;
    logic [GAP_CNT_W-1:0] gap_left_q;
    logic                 term_pend_q;
    logic [GAP_CNT_W-1:0] gap_total;
    logic [GAP_CNT_W-1:0] gap_done_in_word;
    logic                 gap_step;

    assign src_ready = tx_enable && (state_q == ST_OPEN);
    assign accept    = src_ready && src_valid;
    assign close     = accept && src_eop;
    assign gap_step  = (state_q == ST_GAP) && tx_enable;
    assign term_word = gap_step && term_pend_q;

    // Gap owed at frame end, less the idle lanes already in the last word.
    always_comb begin
        gap_total = GAP_CNT_W'(MIN_GAP)
                  + GAP_CNT_W'(gap_cfg) * GAP_CNT_W'(GAP_UNIT)
                  + stretch_bytes;
        gap_done_in_word = GAP_CNT_W'(LANES) - GAP_CNT_W'(tail_cnt);
    end

    // Enter the gap at frame end and leave once the remaining bytes are sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_OPEN;
            gap_left_q  <= '0;
            term_pend_q <= 1'b0;
        end else if (close) begin
            state_q     <= ST_GAP;
            gap_left_q  <= gap_total - gap_done_in_word;
            term_pend_q <= (tail_cnt == CNT_W'(LANES));
        end else if (gap_step) begin
            term_pend_q <= 1'b0;
            if (gap_left_q <= GAP_CNT_W'(LANES)) begin
                state_q    <= ST_OPEN;
                gap_left_q <= '0;
            end else begin
                gap_left_q <= gap_left_q - GAP_CNT_W'(LANES);
            end
        end
    end

    // R5
    gap_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        close |=> !src_ready);

    // R3
    gap_not_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_step && (gap_left_q > GAP_CNT_W'(LANES))) |=> (state_q == ST_GAP));

    // R7
    gap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_GAP) && !tx_enable) |=> $stable(gap_left_q));

endmodule

// File: rtl/xgmii_tx_gap.sv
// Transmit inter-frame gap inserter for an eight-lane single-data-rate bus.
// Maps source words to start/data/terminate lanes, inserts the programmed
// (optionally stretched) idle gap and registers the bus outputs.
// Assumes frames start on lane 0 and the source holds valid within a frame.
module xgmii_tx_gap
    import xgmii_gap_pkg::*;
#(
    parameter int LANES       = 8,
    parameter int GAP_W       = 5,
    parameter int MIN_GAP     = 8,
    parameter int GAP_UNIT    = 4,
    parameter int STRETCH_DIV = 13,
    parameter int EXT_W       = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tx_enable,
    input  logic [GAP_W-1:0]           gap_cfg,
    input  logic                       stretch_en,
    input  logic                       src_valid,
    input  logic                       src_sop,
    input  logic                       src_eop,
    input  logic [$clog2(LANES)-1:0]   src_tail,
    input  logic [8*LANES-1:0]         src_data,
    output logic                       src_ready,
    output logic [8*LANES-1:0]         xgmii_txd,
    output logic [LANES-1:0]           xgmii_txc
);

    localparam int DW        = 8 * LANES;
    localparam int CNT_W     = $clog2(LANES + 1);
    localparam int GAP_CNT_W = EXT_W + GAP_W + 2;

    logic [CNT_W-1:0]     tail_cnt;
    logic [CNT_W-1:0]     data_cnt;
    logic [GAP_CNT_W-1:0] stretch_bytes;
    logic                 accept;
    logic                 close;
    logic                 term_word;
    logic [DW-1:0]        txd_d;
    logic [LANES-1:0]     txc_d;

    assign tail_cnt = (src_tail == '0) ? CNT_W'(LANES) : CNT_W'(src_tail);

    xgmii_gap_ctrl #(
        .LANES(LANES), .GAP_W(GAP_W), .MIN_GAP(MIN_GAP),
        .GAP_UNIT(GAP_UNIT), .CNT_W(CNT_W), .GAP_CNT_W(GAP_CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .gap_cfg(gap_cfg),
        .src_valid(src_valid), .src_sop(src_sop), .src_eop(src_eop),
        .tail_cnt(tail_cnt), .stretch_bytes(stretch_bytes),
        .src_ready(src_ready), .accept(accept), .close(close),
        .term_word(term_word)
    );

    xgmii_lane_mapper #(.LANES(LANES), .CNT_W(CNT_W)) u_map (
        .frame_word(accept), .term_word(term_word), .sop(src_sop),
        .eop(src_eop), .tail_cnt(tail_cnt), .data(src_data),
        .txd(txd_d), .txc(txc_d), .data_cnt(data_cnt)
    );

    xgmii_stretch_acc #(
        .CNT_W(CNT_W), .DIV(STRETCH_DIV), .UNIT(GAP_UNIT),
        .EXT_W(EXT_W), .OUT_W(GAP_CNT_W)
    ) u_stretch (
        .clk(clk), .rst_n(rst_n), .stretch_en(stretch_en),
        .count_en(accept), .add_bytes(data_cnt), .close(close),
        .extra_bytes(stretch_bytes)
    );

    // Register the bus word; reset drives idle on every lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xgmii_txd <= {LANES{CH_IDLE}};
            xgmii_txc <= '1;
        end else begin
            xgmii_txd <= txd_d;
            xgmii_txc <= txc_d;
        end
    end

    // ---- checks on the registered bus ----
    logic [LANES-1:0] term_hits;

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        assign term_hits[i] = xgmii_txc[i] && (xgmii_txd[8*i +: 8] == CH_TERM);

        // R6
        ctrl_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            xgmii_txc[i] |-> ((xgmii_txd[8*i +: 8] == CH_IDLE) ||
                              (xgmii_txd[8*i +: 8] == CH_START) ||
                              (xgmii_txd[8*i +: 8] == CH_TERM)));

        if (i > 0) begin : g_upper
            // R1
            start_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(xgmii_txc[i] && (xgmii_txd[8*i +: 8] == CH_START)));
        end
    end

    // R2
    single_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(term_hits) <= 1);

    // R7
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> ((xgmii_txc == '1) && (xgmii_txd == {LANES{CH_IDLE}})));

endmodule

// File: tb/tb_xgmii_tx_gap.sv
// Directed bench for the transmit gap inserter: one task per scenario.
module tb_xgmii_tx_gap;
    timeunit 1ns;
    timeprecision 100ps;

    localparam time CLK_PERIOD = 6.4ns;
    localparam logic [7:0] IDL = 8'h07, STA = 8'hFB, TRM = 8'hFD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_enable = 1'b1;
    logic [4:0]  gap_cfg = '0;
    logic        stretch_en = 1'b0;
    logic        src_valid = 1'b0;
    logic        src_sop = 1'b0;
    logic        src_eop = 1'b0;
    logic [2:0]  src_tail = '0;
    logic [63:0] src_data = '0;
    logic        src_ready;
    logic [63:0] xgmii_txd;
    logic [7:0]  xgmii_txc;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] tx_seq = 8'd0;
    logic [7:0] rx_seq = 8'd0;
    int data_err = 0;
    int code_err = 0;
    int gaps[64];
    int gap_n = 0;
    bit in_gap = 0;
    int gap_cnt = 0;
    int bm_rem = 0;
    int bm_ext = 0;
    logic [63:0] last_xd;
    logic [7:0]  last_xc;

    xgmii_tx_gap dut (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .gap_cfg(gap_cfg),
        .stretch_en(stretch_en), .src_valid(src_valid), .src_sop(src_sop),
        .src_eop(src_eop), .src_tail(src_tail), .src_data(src_data),
        .src_ready(src_ready), .xgmii_txd(xgmii_txd), .xgmii_txc(xgmii_txc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Bus monitor: data order, control codes and measured gaps.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 8; i++) begin
                logic [7:0] b;
                b = xgmii_txd[8*i +: 8];
                if (xgmii_txc[i]) begin
                    if (b == STA) begin
                        if (in_gap && gap_n < 64) begin
                            gaps[gap_n] = gap_cnt;
                            gap_n++;
                        end
                        in_gap = 0;
                        if (i != 0) code_err++;
                    end else if (b == TRM) begin
                        in_gap = 1;
                        gap_cnt = 1;
                    end else if (b == IDL) begin
                        if (in_gap) gap_cnt++;
                    end else begin
                        code_err++;
                    end
                end else begin
                    if (b != rx_seq) data_err++;
                    rx_seq++;
                end
            end
        end
    end

    function automatic int exp_gap(input int cfg, input int extra, input int tail);
        int g;
        g = 8 + 4 * cfg + extra;
        while (((g + tail) % 8) != 0) g++;
        return g;
    endfunction

    task automatic fill_word(input bit sop, input bit eop, input int tail);
        src_sop = sop;
        src_eop = eop;
        src_tail = 3'(tail % 8);
        for (int i = 0; i < 8; i++) begin
            if ((sop && i == 0) || (eop && i >= tail)) begin
                src_data[8*i +: 8] = 8'hA5;
            end else begin
                src_data[8*i +: 8] = tx_seq;
                tx_seq++;
            end
        end
    endtask

    // Offer one word, wait for acceptance, return just after the accepting edge.
    task automatic push(input bit sop, input bit eop, input int tail);
        @(negedge clk);
        src_valid = 1'b1;
        fill_word(sop, eop, tail);
        while (!src_ready) @(negedge clk);
        @(posedge clk);
        #1;
        last_xd = xgmii_txd;
        last_xc = xgmii_txc;
    endtask

    // Send a frame, track the stretch model and return the expected gap after it.
    task automatic send_frame(input int nwords, input int tail, output int exp_g);
        int extra;
        for (int w = 0; w < nwords; w++) begin
            bit s, e;
            int d;
            s = (w == 0);
            e = (w == nwords - 1);
            d = (e ? tail : 8) - (s ? 1 : 0);
            if (stretch_en) begin
                for (int k = 0; k < d; k++) begin
                    bm_rem++;
                    if (bm_rem == 13) begin bm_rem = 0; bm_ext++; end
                end
            end
            push(s, e, e ? tail : 8);
        end
        if (stretch_en) begin
            extra = (bm_ext / 4) * 4;
            bm_ext = bm_ext % 4;
        end else begin
            extra = 0; bm_ext = 0; bm_rem = 0;
        end
        exp_g = exp_gap(int'(gap_cfg), extra, tail);
        @(negedge clk);
        src_valid = 1'b0;
        src_sop = 1'b0;
        src_eop = 1'b0;
        // R5: source held off in the cycle after the last word
        check(src_ready == 1'b0, "R5", "ready after last word", src_ready, 0);
    endtask

    task automatic flush();
        repeat (40) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        // R9
        check(xgmii_txc == 8'hFF && xgmii_txd == {8{IDL}}, "R9", "bus after reset",
              xgmii_txd, {8{IDL}});
        check(src_ready == 1'b1, "R9", "ready after reset", src_ready, 1);
    endtask

    task automatic t_idle();
        bit ok = 1;
        repeat (3) begin
            @(negedge clk);
            if (!(xgmii_txc == 8'hFF && xgmii_txd == {8{IDL}})) ok = 0;
        end
        // R6
        check(ok, "R6", "idle bus with no source word", xgmii_txd, {8{IDL}});
    endtask

    task automatic t_gap(input int cfg, input int nwords, input int tail, input string req);
        int e, dummy;
        @(negedge clk);
        gap_cfg = 5'(cfg);
        send_frame(nwords, tail, e);
        send_frame(2, 8, dummy);
        flush();
        check(gap_n > 0 && gaps[gap_n-1] == e, req, "measured gap",
              gaps[gap_n-1], e);
    endtask

    task automatic t_term_partial();
        int e;
        logic [7:0] ec;
        @(negedge clk);
        gap_cfg = 5'd0;
        send_frame(2, 3, e);
        ec = 8'b1111_1000;
        // R2: lanes 0..2 data, lane 3 terminate, lanes 4..7 idle
        check(last_xc == ec && last_xd[31:24] == TRM && last_xd[63:32] == {4{IDL}},
              "R2", "partial last word", {last_xd[63:24], last_xc}, {{4{IDL}}, TRM, ec});
        flush();
    endtask

    task automatic t_term_full();
        int e;
        @(negedge clk);
        send_frame(2, 8, e);
        // R2: full last word is all data
        check(last_xc == 8'h00, "R2", "full last word flags", last_xc, 0);
        @(posedge clk);
        #1;
        check(xgmii_txc == 8'hFF && xgmii_txd == {{7{IDL}}, TRM}, "R2",
              "word after full last word", xgmii_txd, {{7{IDL}}, TRM});
        flush();
    endtask

    task automatic t_single_word();
        int e;
        @(negedge clk);
        send_frame(1, 4, e);
        // R5, R1: word visible right after its accepting edge; start on lane 0
        check(last_xc == 8'b1111_0001 && last_xd[7:0] == STA && last_xd[39:32] == TRM
              && last_xd[63:40] == {3{IDL}}, "R5", "single-word frame output",
              {last_xd, last_xc}, 8'b1111_0001);
        flush();
    endtask

    task automatic t_disable();
        bit rdy_ok = 1, idle_ok = 1;
        @(negedge clk);
        tx_enable = 1'b0;
        @(negedge clk);
        src_valid = 1'b1;
        fill_word(1'b1, 1'b1, 5);
        repeat (4) begin
            @(negedge clk);
            if (src_ready) rdy_ok = 0;
            if (!(xgmii_txc == 8'hFF && xgmii_txd == {8{IDL}})) idle_ok = 0;
        end
        // R7
        check(rdy_ok, "R7", "ready while disabled", src_ready, 0);
        check(idle_ok, "R7", "bus idle while disabled", xgmii_txd, {8{IDL}});
        tx_enable = 1'b1;
        @(posedge clk);
        #1;
        check(xgmii_txc[0] && xgmii_txd[7:0] == STA, "R7", "frame sent after enable",
              xgmii_txd[7:0], STA);
        @(negedge clk);
        src_valid = 1'b0;
        src_sop = 1'b0;
        src_eop = 1'b0;
        flush();
    endtask

    task automatic t_stretch();
        int e1, e2, e3, e4, e5;
        @(negedge clk);
        gap_cfg = 5'd0;
        stretch_en = 1'b1;
        bm_rem = 0;
        bm_ext = 0;
        send_frame(7, 8, e1);
        send_frame(2, 6, e2);
        send_frame(3, 8, e3);
        send_frame(3, 8, e4);
        send_frame(1, 8, e5);
        flush();
        // R8: expected 16, 10, 8, 16 bytes
        check(gaps[gap_n-4] == e1 && e1 == 16, "R8", "stretched gap 1", gaps[gap_n-4], e1);
        check(gaps[gap_n-3] == e2 && e2 == 10, "R8", "stretched gap 2", gaps[gap_n-3], e2);
        check(gaps[gap_n-2] == e3 && e3 == 8,  "R8", "stretched gap 3", gaps[gap_n-2], e3);
        check(gaps[gap_n-1] == e4 && e4 == 16, "R8", "stretched gap 4 (carry)", gaps[gap_n-1], e4);
        @(negedge clk);
        stretch_en = 1'b0;
        flush();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle();
        t_gap(0, 2, 3, "R3");
        t_gap(0, 2, 8, "R4");
        t_gap(5, 3, 5, "R3");
        t_gap(31, 2, 1, "R4");
        t_gap(2, 1, 4, "R3");
        t_term_partial();
        t_term_full();
        t_single_word();
        t_disable();
        t_stretch();
        // R1: every data byte arrived in order on a data lane
        check(data_err == 0 && rx_seq == tx_seq, "R1", "data order errors",
              data_err, 0);
        // R6, R1: only known control codes, start only on lane 0
        check(code_err == 0, "R6", "control code errors", code_err, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule